// File: doc/BRIEF.md
# Memory Word Pattern Self-Test Engine

The engine exercises a word-wide memory through a simple request port and reports how many words came back wrong. A run begins with a short data-bus probe at the base address. It writes two complementary alternating-bit words, reads each one back and compares it. The engine then fills a region of consecutive word addresses with a generated sequence. Last, it regenerates that same sequence from the same starting seed and checks every word it reads back.

A mode input, sampled only when a run starts, selects the sequence. One choice is a pseudo-random linear congruential sequence. The other is a plain incrementing counter, which is far easier to follow on a logic analyser when real hardware misbehaves. The verify pass keeps only one read outstanding and waits for the read-valid strobe, so the memory may take any number of cycles to answer. Each run ends with a one-cycle done pulse, and the error count stays readable until the next start.

Top module: `memtest_engine`

## Requirements
- R1: While reset is asserted, and after it is released, busy, done and mem_req are 0 and err_count is 0.
- R2: A start pulse while idle latches rand_mode, clears err_count and raises busy on the next cycle. Start and rand_mode have no effect while busy is high.
- R3: The bus probe writes 0xAAAAAAAA to BASE_ADDR and reads it back, then does the same with 0x55555555. Each read-back that differs adds one to err_count.
- R4: The fill pass writes WORDS words to addresses BASE_ADDR up to BASE_ADDR+WORDS-1 in ascending order. The seed is set to 0 when the pass begins and is advanced before each word is produced, so the first word is the generator output for seed 0.
- R5: With rand_mode=1 the generator step is seed*1664525 + 1013904223 modulo 2^32, so the first word is 0x3C6EF35F.
- R6: With rand_mode=0 the generator step is seed+1, so word k of the region holds k+1.
- R7: The verify pass resets the seed to 0 and reads the region in ascending order. A new read is issued only after the read-valid strobe for the previous one, so any read latency of one cycle or more gives a correct comparison.
- R8: Every verify-pass word that differs from the regenerated value adds exactly one to err_count. err_count never grows by more than one per cycle, and the final count is the bus-probe mismatches plus the sequence mismatches.
- R9: done is high for exactly one cycle after the last comparison, and busy is low in that cycle.
- R10: Between the end of a run and the next start, err_count holds its value and no memory request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (used only when idle) |
| rand_mode | input | 1 | 1 = pseudo-random sequence, 0 = counter sequence |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| err_count | output | 32 | Mismatching words in the last run |
| mem_req | output | 1 | Memory request valid this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_rvalid |
| mem_rvalid | input | 1 | Read data strobe |

## Verification
The assertions watch the port-level rules on every cycle. They check that done lasts one cycle and never coincides with busy, that no request leaves the block while it is idle, and that a read is never followed directly by another request. They also check that the error count moves by at most one per cycle and stays frozen while idle. Only the bench scenarios can show that the stored words match the chosen sequence, and that the final count equals the injected stuck-bit faults for each mode and latency. They also show that a start or mode change in the middle of a run is ignored.

// File: rtl/memtest_engine.sv
module memtest_engine #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int WORDS = 524288
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rand_mode,
  output logic              busy,
  output logic              done,
  output logic [31:0]       err_count,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_rvalid
);
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

  typedef enum logic [2:0] {IDLE, BUS_WR, BUS_RD, BUS_WAIT, FILL, VER_RD, VER_WAIT} st_t;

  st_t              st;
  logic             mode_q, pat_sel;
  logic [IDX_W-1:0] idx;
  logic [31:0]      seed, next_word, pat;

  assign next_word = mode_q ? seed * 32'd1664525 + 32'd1013904223 : seed + 32'd1;
  assign pat       = pat_sel ? 32'h5555_5555 : 32'hAAAA_AAAA;

  assign busy      = (st != IDLE);
  assign mem_req   = (st == BUS_WR) || (st == BUS_RD) || (st == FILL) || (st == VER_RD);
  assign mem_we    = (st == BUS_WR) || (st == FILL);
  assign mem_addr  = (st == FILL || st == VER_RD) ? BASE_ADDR + ADDR_W'(idx) : BASE_ADDR;
  assign mem_wdata = (st == FILL) ? next_word : pat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      mode_q    <= 1'b0;
      pat_sel   <= 1'b0;
      idx       <= '0;
      seed      <= '0;
      err_count <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          mode_q    <= rand_mode;
          err_count <= '0;
          pat_sel   <= 1'b0;
          st        <= BUS_WR;
        end
        BUS_WR: st <= BUS_RD;
        BUS_RD: st <= BUS_WAIT;
        BUS_WAIT: if (mem_rvalid) begin
          if (mem_rdata != pat) err_count <= err_count + 32'd1;
          if (!pat_sel) begin
            pat_sel <= 1'b1;
            st      <= BUS_WR;
          end else begin
            idx  <= '0;
            seed <= '0;
            st   <= FILL;
          end
        end
        FILL: begin
          if (idx == LAST) begin
            idx  <= '0;
            seed <= '0;
            st   <= VER_RD;
          end else begin
            idx  <= idx + 1'b1;
            seed <= next_word;
          end
        end
        VER_RD: st <= VER_WAIT;
        VER_WAIT: if (mem_rvalid) begin
          if (mem_rdata != next_word) err_count <= err_count + 32'd1;
          seed <= next_word;
          if (idx == LAST) begin
            done <= 1'b1;
            st   <= IDLE;
          end else begin
            idx <= idx + 1'b1;
            st  <= VER_RD;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/memtest_engine_chk.sv
module memtest_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [31:0] err_count,
  input logic        mem_req,
  input logic        mem_we
);
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_idle_no_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(err_count));

  p_one_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> !mem_req);

  p_err_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (err_count == $past(err_count) || err_count == $past(err_count) + 32'd1));

  always_comb begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!done && !mem_req);
    end
  end
endmodule

bind memtest_engine memtest_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err_count(err_count), .mem_req(mem_req), .mem_we(mem_we)
);

// File: tb/tb_memtest_engine.sv
module tb_memtest_engine;
  localparam int AW = 16;
  localparam logic [AW-1:0] BASE = 16'h0040;
  localparam int WORDS = 256;
  localparam int NV = 6;

  localparam int          V_MODE[NV] = '{1, 0, 0, 1, 1, 0};
  localparam int          V_LAT [NV] = '{1, 1, 3, 4, 7, 2};
  localparam int          V_FADR[NV] = '{5, 3, 2, 2, 0, 255};
  localparam logic [31:0] V_MASK[NV] = '{32'h0, 32'h8000_0000, 32'h1, 32'h1, 32'h1, 32'hFFFF_0000};

  logic clk = 0, rst_n = 0, start = 0, rand_mode = 0;
  logic busy, done, mem_req, mem_we, mem_rvalid;
  logic [31:0] err_count, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;

  int checks = 0, errors = 0;
  int lat = 1, faddr = -1, oob = 0;
  logic [31:0] fmask = '0;

  logic [31:0] mem [WORDS];
  int cnt = 0;
  int raddr = 0;

  always #4 clk = ~clk;

  memtest_engine #(.ADDR_W(AW), .BASE_ADDR(BASE), .WORDS(WORDS)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rand_mode(rand_mode),
    .busy(busy), .done(done), .err_count(err_count),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
  );

  always @(posedge clk) begin
    int a;
    a = int'(mem_addr) - int'(BASE);
    mem_rvalid <= 1'b0;
    if (mem_req && (a < 0 || a >= WORDS)) oob <= oob + 1;
    else if (mem_req && mem_we) mem[a] <= (a == faddr) ? (mem_wdata | fmask) : mem_wdata;
    else if (mem_req) begin
      cnt   <= lat;
      raddr <= a;
    end
    if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[raddr];
      end
    end
  end

  function automatic logic [31:0] gen(logic [31:0] s, int m);
    return (m != 0) ? s * 32'd1664525 + 32'd1013904223 : s + 32'd1;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start(int m);
    @(negedge clk);
    rand_mode = m[0];
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      if (done) begin ok = 1; break; end
      @(negedge clk);
    end
    if (!ok) begin
      checks++; errors++;
      $display("FAIL R9 watchdog: actual no done expected done");
    end
  endtask

  function automatic int expect_errs(int m, int fa, logic [31:0] fm);
    int n = 0;
    logic [31:0] s = 0;
    if (fa == 0) begin
      if ((32'hAAAA_AAAA | fm) != 32'hAAAA_AAAA) n++;
      if ((32'h5555_5555 | fm) != 32'h5555_5555) n++;
    end
    for (int i = 0; i < WORDS; i++) begin
      s = gen(s, m);
      if (i == fa && (s | fm) != s) n++;
    end
    return n;
  endfunction

  function automatic int region_bad(int m, int fa, logic [31:0] fm);
    int n = 0;
    logic [31:0] s = 0;
    for (int i = 0; i < WORDS; i++) begin
      s = gen(s, m);
      if (mem[i] !== ((i == fa) ? (s | fm) : s)) n++;
    end
    return n;
  endfunction

  task automatic run_vec(int m, int l, int fa, logic [31:0] fm, int v);
    bit ok;
    string tag;
    tag = $sformatf("vec%0d", v);
    lat = l; faddr = fa; fmask = fm;
    pulse_start(m);
    check("R2", {tag, " busy after start"}, {31'b0, busy}, 32'd1);
    wait_done(ok);
    if (ok) begin
      check("R9", {tag, " busy low with done"}, {31'b0, busy}, 32'd0);
      check("R8", {tag, " error count"}, err_count, 32'(expect_errs(m, fa, fm)));
      check("R4", {tag, " region contents"}, 32'(region_bad(m, fa, fm)), 32'd0);
      @(negedge clk);
      check("R9", {tag, " done one cycle"}, {31'b0, done}, 32'd0);
    end
  endtask

  initial begin
    bit ok;
    logic [31:0] held;
    for (int i = 0; i < WORDS; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", {31'b0, busy}, 32'd0);
    check("R1", "req in reset", {31'b0, mem_req}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1", "done after reset", {31'b0, done}, 32'd0);
    check("R1", "err after reset", err_count, 32'd0);

    for (int v = 0; v < NV; v++) run_vec(V_MODE[v], V_LAT[v], V_FADR[v], V_MASK[v], v);

    // R5 first random word, R6 counter words, from fresh fault-free runs
    lat = 2; faddr = -1; fmask = '0;
    pulse_start(1);
    wait_done(ok);
    check("R5", "first random word", mem[0], 32'h3C6E_F35F);
    check("R5", "second random word", mem[1], gen(32'h3C6E_F35F, 1));
    pulse_start(0);
    wait_done(ok);
    check("R6", "first counter word", mem[0], 32'd1);
    check("R6", "last counter word", mem[WORDS-1], 32'(WORDS));

    // R3 bus probe: a bit stuck high at the base hits 0x55555555 only in bit 1
    lat = 5; faddr = 0; fmask = 32'h2;
    pulse_start(0);
    wait_done(ok);
    check("R3", "bus probe mismatch count", err_count, 32'(expect_errs(0, 0, 32'h2)));
    // R10 hold after run with nonzero count
    held = err_count;
    repeat (25) @(negedge clk);
    check("R10", "count held while idle", err_count, held);
    check("R10", "no done while idle", {31'b0, done}, 32'd0);
    check("R2", "start clears count", held, 32'd2);

    // R2/R7 start and mode change during a run are ignored
    lat = 6; faddr = -1; fmask = '0;
    pulse_start(0);
    repeat (40) @(negedge clk);
    rand_mode = 1; start = 1;
    @(negedge clk);
    start = 0;
    wait_done(ok);
    check("R2", "mid-run restart ignored, count", err_count, 32'd0);
    check("R2", "mid-run mode ignored, word 1", mem[1], 32'd2);
    check("R7", "no out-of-range access", 32'(oob), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule